// File: doc/BRIEF.md
# Branch Condition and Loop Unit

This unit makes the control-flow decision for a processor's conditional branch and counted-loop instructions. A 4-bit selector picks one of sixteen tests on the negative, zero, overflow and carry flags. In branch mode the unit reports whether the branch is taken. It also reports whether the selector held the encoding that is reused as a subroutine call.

In loop mode the unit receives the 32-bit counter register and returns the updated register with a write enable and a taken signal. When the selected condition holds, the loop exits at once and the counter is left alone. Otherwise only the low 16 bits count down, and the loop repeats unless that field has just wrapped to all ones.

Decode, target arithmetic and pipeline control lie outside the unit. Each request is presented for one cycle with `req_valid`. Its result appears, registered, on the next cycle with `res_valid`.

Top module: `branch_loop_unit`

## Requirements
- R1: While `rst_n` is low, and after reset until the first request, `res_valid`, `res_taken`, `res_call`, `res_wr_en` and `count_out` are all 0.
- R2: The selector gives this condition (N, Z, V, C are the flags): 0 true, 1 false, 2 !C&!Z, 3 C|Z, 4 !C, 5 C, 6 !Z, 7 Z, 8 !V, 9 V, 10 !N, 11 N, 12 N==V, 13 N!=V, 14 !Z&(N==V), 15 Z|(N!=V).
- R3: In branch mode (`loop_mode`=0), `res_taken` equals the selected condition, so selector 0 is always taken; `res_wr_en` is 0 and `count_out` equals `count_in`.
- R4: In branch mode, selector 1 gives `res_taken`=1 and `res_call`=1. `res_call` is 0 for every other selector and in loop mode.
- R5: In loop mode (`loop_mode`=1), a true condition gives `res_taken`=0, `res_wr_en`=0 and `count_out`=`count_in`.
- R6: In loop mode with a false condition (selector 1 is never true, so it makes a pure counted loop), `res_wr_en`=1 and `count_out[15:0]` = (`count_in[15:0]` - 1) mod 65536.
- R7: In that decrement case, `res_taken` is 1 unless the new `count_out[15:0]` equals 16'hFFFF, which happens when the old low field was 0.
- R8: `count_out[31:16]` always equals `count_in[31:16]` of the request.
- R9: The results of a request appear on the cycle after the `req_valid` cycle, with `res_valid`=1. On a cycle following one without a request, `res_valid`, `res_taken`, `res_call` and `res_wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| loop_mode | input | 1 | 0 branch decision, 1 decrement-and-branch |
| cond_sel | input | 4 | Condition selector |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| count_in | input | 32 | Counter register value (loop mode) |
| res_valid | output | 1 | Result is present |
| res_taken | output | 1 | Branch taken |
| res_call | output | 1 | The subroutine-call encoding was used |
| res_wr_en | output | 1 | Write `count_out` back to the counter register |
| count_out | output | 32 | Updated counter register value |

## Verification
The assertions assume that a request's inputs are steady over the cycle in which `req_valid` is high, because several of them compare the registered result with `$past` of the request fields. The stimulus changes inputs only on the falling clock edge and holds them through the next rising edge. The bench sweeps both modes, every selector and every flag combination. The counter values are rotated through a set that includes a low field of 0 (the wrap to all ones) and a low field of 1 (a decrement to zero that is still taken), with nonzero upper halves.

// File: rtl/bcl_pkg.sv
package bcl_pkg;

  typedef enum logic [3:0] {
    SEL_ALWAYS = 4'd0,
    SEL_NEVER  = 4'd1,
    SEL_HI     = 4'd2,
    SEL_LS     = 4'd3,
    SEL_CC     = 4'd4,
    SEL_CS     = 4'd5,
    SEL_NE     = 4'd6,
    SEL_EQ     = 4'd7,
    SEL_VC     = 4'd8,
    SEL_VS     = 4'd9,
    SEL_PL     = 4'd10,
    SEL_MI     = 4'd11,
    SEL_GE     = 4'd12,
    SEL_LT     = 4'd13,
    SEL_GT     = 4'd14,
    SEL_LE     = 4'd15
  } cond_sel_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  // Full truth of the sixteen selector tests.
  function automatic logic eval_cond(input cond_sel_e sel, input flags_t f);
    logic r;
    case (sel)
      SEL_ALWAYS: r = 1'b1;
      SEL_NEVER:  r = 1'b0;
      SEL_HI:     r = !f.c && !f.z;
      SEL_LS:     r = f.c || f.z;
      SEL_CC:     r = !f.c;
      SEL_CS:     r = f.c;
      SEL_NE:     r = !f.z;
      SEL_EQ:     r = f.z;
      SEL_VC:     r = !f.v;
      SEL_VS:     r = f.v;
      SEL_PL:     r = !f.n;
      SEL_MI:     r = f.n;
      SEL_GE:     r = !(f.n ^ f.v);
      SEL_LT:     r = f.n ^ f.v;
      SEL_GT:     r = !f.z && !(f.n ^ f.v);
      SEL_LE:     r = f.z || (f.n ^ f.v);
      default:    r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bcl_cond_eval.sv
module bcl_cond_eval
  import bcl_pkg::*;
(
  input  logic [3:0] sel,
  input  flags_t     flags,
  output logic       cond_true,
  output logic       sel_never
);
  cond_sel_e sel_e;

  assign sel_e     = cond_sel_e'(sel);
  assign cond_true = eval_cond(sel_e, flags);
  assign sel_never = (sel_e == SEL_NEVER);
endmodule

// File: rtl/bcl_loop_step.sv
module bcl_loop_step #(
  parameter int CNT_W  = 32,
  parameter int LOOP_W = 16
) (
  input  logic [CNT_W-1:0] count_in,
  output logic [CNT_W-1:0] count_dec,
  output logic             low_wraps
);
  localparam int HIGH_W = CNT_W - LOOP_W;

  // Decrement only the loop field; the upper part passes through.
  function automatic logic [CNT_W-1:0] dec_low(input logic [CNT_W-1:0] v);
    logic [LOOP_W-1:0] lo;
    lo = v[LOOP_W-1:0] - {{(LOOP_W-1){1'b0}}, 1'b1};
    return {v[CNT_W-1:LOOP_W], lo};
  endfunction

  generate
    if (HIGH_W > 0) begin : g_split
      assign count_dec = dec_low(count_in);
    end else begin : g_full
      assign count_dec = count_in - {{(CNT_W-1){1'b0}}, 1'b1};
    end
  endgenerate

  // A zero field wraps to all ones and ends the loop.
  assign low_wraps = (count_in[LOOP_W-1:0] == '0);
endmodule

// File: rtl/branch_loop_unit.sv
module branch_loop_unit
  import bcl_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int LOOP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             loop_mode,
  input  logic [3:0]       cond_sel,
  input  logic             flag_n,
  input  logic             flag_z,
  input  logic             flag_v,
  input  logic             flag_c,
  input  logic [CNT_W-1:0] count_in,
  output logic             res_valid,
  output logic             res_taken,
  output logic             res_call,
  output logic             res_wr_en,
  output logic [CNT_W-1:0] count_out
);
  flags_t           flags;
  logic             cond_true;
  logic             sel_never;
  logic [CNT_W-1:0] count_dec;
  logic             low_wraps;

  assign flags = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};

  bcl_cond_eval u_cond (
    .sel       (cond_sel),
    .flags     (flags),
    .cond_true (cond_true),
    .sel_never (sel_never)
  );

  bcl_loop_step #(.CNT_W(CNT_W), .LOOP_W(LOOP_W)) u_step (
    .count_in  (count_in),
    .count_dec (count_dec),
    .low_wraps (low_wraps)
  );

  logic             nxt_taken;
  logic             nxt_call;
  logic             nxt_wr;
  logic [CNT_W-1:0] nxt_cnt;

  always_comb begin
    nxt_taken = 1'b0;
    nxt_call  = 1'b0;
    nxt_wr    = 1'b0;
    nxt_cnt   = '0;
    if (req_valid) begin
      nxt_cnt = count_in;
      if (!loop_mode) begin
        nxt_taken = cond_true || sel_never;
        nxt_call  = sel_never;
      end else if (!cond_true) begin
        nxt_wr    = 1'b1;
        nxt_cnt   = count_dec;
        nxt_taken = !low_wraps;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_taken <= 1'b0;
      res_call  <= 1'b0;
      res_wr_en <= 1'b0;
      count_out <= '0;
    end else begin
      res_valid <= req_valid;
      res_taken <= nxt_taken;
      res_call  <= nxt_call;
      res_wr_en <= nxt_wr;
      count_out <= nxt_cnt;
    end
  end

  // R9
  result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  // R9
  idle_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid && !res_taken && !res_call && !res_wr_en);
  // R8
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> count_out[CNT_W-1:LOOP_W] == $past(count_in[CNT_W-1:LOOP_W]));
  // R4
  call_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_call |-> res_taken && !res_wr_en);
  // R4
  call_branch_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && loop_mode |=> !res_call);
  // R7
  loop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr_en && res_taken |-> count_out[LOOP_W-1:0] != '1);
  // R5
  no_write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!res_wr_en -> count_out == $past(count_in)));
  // R3
  branch_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !loop_mode |=> !res_wr_en);
endmodule

// File: tb/test_branch_loop_unit.sv
module test_branch_loop_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        loop_mode = 1'b0;
  logic [3:0]  cond_sel = 4'd0;
  logic        flag_n = 1'b0, flag_z = 1'b0, flag_v = 1'b0, flag_c = 1'b0;
  logic [31:0] count_in = 32'd0;
  logic        res_valid, res_taken, res_call, res_wr_en;
  logic [31:0] count_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  branch_loop_unit i_branch_loop_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .loop_mode(loop_mode),
    .cond_sel(cond_sel), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
    .flag_c(flag_c), .count_in(count_in), .res_valid(res_valid),
    .res_taken(res_taken), .res_call(res_call), .res_wr_en(res_wr_en),
    .count_out(count_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Selectors come in true/inverted pairs: base test, odd value inverts (R2).
  function automatic logic ref_cond(input int s, input logic n, z, v, c);
    logic b;
    case (s / 2)
      0: b = 1'b1;
      1: b = ~(c | z);
      2: b = ~c;
      3: b = ~z;
      4: b = ~v;
      5: b = ~n;
      6: b = (n == v);
      default: b = ~z & (n == v);
    endcase
    return b ^ s[0];
  endfunction

  function automatic logic [31:0] pick_count(input int k);
    case (k % 6)
      0: return 32'hA5A5_0000;
      1: return 32'h1234_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h0000_8000;
      4: return 32'h7E01_0000 + k;
      default: return k * 32'h9E37_79B9;
    endcase
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int k = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid", {31'd0, res_valid}, 32'd0);
    check("R1 taken/call/wr", {29'd0, res_taken, res_call, res_wr_en}, 32'd0);
    check("R1 count", count_out, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {28'd0, res_valid, res_taken, res_call, res_wr_en}, 32'd0);

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 16; s++) begin
        for (int f = 0; f < 16; f++) begin
          logic cnd, e_taken, e_call, e_wr;
          logic [31:0] cnt, e_cnt;
          logic [15:0] lo;
          cnt = pick_count(k);
          k++;
          req_valid = 1'b1;
          loop_mode = m[0];
          cond_sel  = s[3:0];
          {flag_n, flag_z, flag_v, flag_c} = f[3:0];
          count_in  = cnt;
          cnd = ref_cond(s, f[3], f[2], f[1], f[0]);
          e_call = 1'b0;
          e_wr = 1'b0;
          e_cnt = cnt;
          if (m == 0) begin
            e_taken = cnd | (s == 1);
            e_call  = (s == 1);
          end else if (cnd) begin
            e_taken = 1'b0;
          end else begin
            lo = cnt[15:0] - 16'd1;
            e_wr = 1'b1;
            e_cnt = {cnt[31:16], lo};
            e_taken = (lo != 16'hFFFF);
          end
          @(negedge clk);
          check("R9 valid", {31'd0, res_valid}, 32'd1);
          if (m == 0) begin
            check("R2 R3 branch taken", {31'd0, res_taken}, {31'd0, e_taken});
            check("R4 call", {31'd0, res_call}, {31'd0, e_call});
            check("R3 no write", {31'd0, res_wr_en}, 32'd0);
            check("R3 R8 count", count_out, e_cnt);
          end else if (cnd) begin
            check("R2 R5 loop exit taken", {31'd0, res_taken}, 32'd0);
            check("R5 no write", {31'd0, res_wr_en}, 32'd0);
            check("R5 R8 count kept", count_out, e_cnt);
            check("R4 no call in loop", {31'd0, res_call}, 32'd0);
          end else begin
            check("R6 write", {31'd0, res_wr_en}, 32'd1);
            check("R6 R8 count decremented", count_out, e_cnt);
            check("R7 loop taken", {31'd0, res_taken}, {31'd0, e_taken});
            check("R4 no call in loop", {31'd0, res_call}, 32'd0);
          end
        end
      end
    end

    // R9: a gap cycle produces no result
    req_valid = 1'b0;
    @(negedge clk);
    check("R9 idle", {28'd0, res_valid, res_taken, res_call, res_wr_en}, 32'd0);

    // R7 boundary: low field 1 decrements to 0 and repeats, low field 0 ends
    req_valid = 1'b1; loop_mode = 1'b1; cond_sel = 4'd1; count_in = 32'hCAFE_0001;
    @(negedge clk);
    check("R7 one to zero taken", {31'd0, res_taken}, 32'd1);
    check("R6 one to zero count", count_out, 32'hCAFE_0000);
    count_in = 32'hCAFE_0000;
    @(negedge clk);
    check("R7 zero wraps not taken", {31'd0, res_taken}, 32'd0);
    check("R8 wrap keeps upper", count_out, 32'hCAFE_FFFF);
    req_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule